// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

The block sits right after instruction fetch in a small 64-bit processor whose instructions are one, two, nine or ten bytes long. Each cycle it takes a ten-byte window read at the program counter and the program counter itself. It splits the leading byte into an instruction class and a function code. It works out the instruction length from the class alone and picks the register specifiers and the eight-byte constant out of the bytes that follow. It also produces the address of the next sequential instruction and raises a flag when the encoding is not legal.

Every output is registered. A window presented before a rising clock edge is reported, fully decoded, after that edge. A synchronous active-high reset puts the outputs in a neutral state.

Window byte k, which is the byte at address PC+k, sits on bits 8k+7..8k of the window input. Byte 0 is the first byte of the instruction.

Top module: `insn_fetch_decoder`

## Requirements
- R1: Bits 7..4 of window byte 0 appear on the class output and bits 3..0 on the function output, for every one of the 256 values of that byte.
- R2: Classes 0x0 (halt), 0x1 (nop) and 0x9 (return) with function 0 report a length of 1. Both register outputs read 0xF and the constant reads 0.
- R3: Classes 0x2 (conditional move, function 0..6), 0x6 (arithmetic, function 0..3), 0xA (push, function 0) and 0xB (pop, function 0) report a length of 2. Register A comes from bits 7..4 and register B from bits 3..0 of byte 1, and the constant reads 0.
- R4: Classes 0x3, 0x4 and 0x5 with function 0 report a length of 10. The registers are taken from byte 1 as in R3, and the constant comes from bytes 2..9.
- R5: Classes 0x7 (jump, function 0..6) and 0x8 (call, function 0) report a length of 9. They have no register byte, so both register outputs read 0xF. The constant comes from bytes 1..8.
- R6: Constants are little-endian: the lowest-addressed constant byte is bits 7..0 of the constant output. The bytes 00 01 00 00 00 00 00 00 give 0x100.
- R7: Register fields are passed through unchanged, including the value 0xF ("no register") in the immediate-load A field and the push/pop B field.
- R8: For a legal instruction, the next-PC output equals PC plus the length, modulo 2^64.
- R9: The invalid flag is set when the class is above 0xB. It is also set when the function code is out of range: above 6 for classes 0x2 and 0x7, above 3 for class 0x6, or nonzero for any other class.
- R10: While the invalid flag is set, the length is 0, the next PC equals PC, both registers read 0xF and the constant reads 0.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. While reset is high at an edge, the outputs go to class 0, function 0, registers 0xF, constant 0, length 0, next PC 0 and flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 64 | Address of window byte 0 |
| win_i | input | 80 | Fetched bytes; byte k on bits 8k+7..8k |
| op_class_o | output | 4 | Instruction class (high nibble of byte 0) |
| op_func_o | output | 4 | Function code (low nibble of byte 0) |
| reg_a_o | output | 4 | First register specifier, 0xF if absent |
| reg_b_o | output | 4 | Second register specifier, 0xF if absent |
| const_o | output | 64 | Immediate, displacement or destination |
| len_o | output | 4 | Instruction length in bytes, 0 if invalid |
| next_pc_o | output | 64 | Sequential successor address |
| bad_op_o | output | 1 | Illegal encoding |

## Verification
The assertions check on every cycle that the outputs agree with each other. The length is always one of the legal values or 0 with the flag set. Absent registers and constants read as their neutral values, and the reported class matches the reported length. The next PC is checked against the previous cycle's PC plus the reported length. Only the bench can show that each field comes from the right byte positions and that the byte order of the constant is correct. The same goes for the exact boundaries between legal and illegal function codes and for wraparound near the top of the address space. To cover these, the bench sweeps all 256 leading bytes with varied trailing bytes and compares them against a behavioural encoder model.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NO_REG = 4'hF;

  typedef enum logic [NIB_W-1:0] {
    OC_HALT  = 4'h0,
    OC_NOP   = 4'h1,
    OC_CMOV  = 4'h2,
    OC_LDIMM = 4'h3,
    OC_STORE = 4'h4,
    OC_LOAD  = 4'h5,
    OC_ALU   = 4'h6,
    OC_JUMP  = 4'h7,
    OC_CALL  = 4'h8,
    OC_RET   = 4'h9,
    OC_PUSH  = 4'hA,
    OC_POP   = 4'hB
  } op_class_e;

  // Layout of one instruction as derived from its leading byte.
  typedef struct packed {
    logic [NIB_W-1:0] len;
    logic             has_regs;   // register byte at offset 1
    logic             cst_at1;    // constant starts at offset 1
    logic             cst_at2;    // constant starts at offset 2
    logic             bad;
  } shape_t;
endpackage

// File: rtl/ifd_classify.sv
module ifd_classify
  import ifd_pkg::*;
(
  input  logic [NIB_W-1:0] op_class,
  input  logic [NIB_W-1:0] op_func,
  output shape_t           shape
);
  logic func_zero, func_le6, func_le3;

  always_comb begin
    func_zero = (op_func == '0);
    func_le6  = (op_func <= 4'd6);
    func_le3  = (op_func <= 4'd3);
    shape     = '0;
    case (op_class)
      OC_HALT, OC_NOP, OC_RET: begin
        shape.len = 4'd1;
        shape.bad = !func_zero;
      end
      OC_CMOV: begin
        shape.len = 4'd2; shape.has_regs = 1'b1; shape.bad = !func_le6;
      end
      OC_ALU: begin
        shape.len = 4'd2; shape.has_regs = 1'b1; shape.bad = !func_le3;
      end
      OC_PUSH, OC_POP: begin
        shape.len = 4'd2; shape.has_regs = 1'b1; shape.bad = !func_zero;
      end
      OC_LDIMM, OC_STORE, OC_LOAD: begin
        shape.len = 4'd10; shape.has_regs = 1'b1; shape.cst_at2 = 1'b1;
        shape.bad = !func_zero;
      end
      OC_JUMP: begin
        shape.len = 4'd9; shape.cst_at1 = 1'b1; shape.bad = !func_le6;
      end
      OC_CALL: begin
        shape.len = 4'd9; shape.cst_at1 = 1'b1; shape.bad = !func_zero;
      end
      default: shape.bad = 1'b1;
    endcase
    if (shape.bad) begin
      shape.len      = '0;
      shape.has_regs = 1'b0;
      shape.cst_at1  = 1'b0;
      shape.cst_at2  = 1'b0;
    end
  end
endmodule

// File: rtl/ifd_extract.sv
module ifd_extract
  import ifd_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int WIN_BYTES = 10
) (
  input  logic [8*WIN_BYTES-1:0] win,
  input  shape_t                 shape,
  output logic [NIB_W-1:0]       reg_a,
  output logic [NIB_W-1:0]       reg_b,
  output logic [WORD_W-1:0]      cval
);
  localparam int CBYTES = WORD_W / 8;

  logic [WORD_W-1:0] cst_from1, cst_from2;

  // Little-endian gather: lowest address lands in the lowest byte lane.
  for (genvar k = 0; k < CBYTES; k++) begin : g_lane
    assign cst_from1[8*k +: 8] = win[8*(k+1) +: 8];
    assign cst_from2[8*k +: 8] = win[8*(k+2) +: 8];
  end

  always_comb begin
    reg_a = NO_REG;
    reg_b = NO_REG;
    if (shape.has_regs) begin
      reg_a = win[15:12];
      reg_b = win[11:8];
    end
    cval = '0;
    if (shape.cst_at1)      cval = cst_from1;
    else if (shape.cst_at2) cval = cst_from2;
  end
endmodule

// File: rtl/insn_fetch_decoder.sv
module insn_fetch_decoder
  import ifd_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int WIN_BYTES = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WORD_W-1:0]      pc_i,
  input  logic [8*WIN_BYTES-1:0] win_i,
  output logic [NIB_W-1:0]       op_class_o,
  output logic [NIB_W-1:0]       op_func_o,
  output logic [NIB_W-1:0]       reg_a_o,
  output logic [NIB_W-1:0]       reg_b_o,
  output logic [WORD_W-1:0]      const_o,
  output logic [NIB_W-1:0]       len_o,
  output logic [WORD_W-1:0]      next_pc_o,
  output logic                   bad_op_o
);
  shape_t            shape;
  logic [NIB_W-1:0]  ra_c, rb_c;
  logic [WORD_W-1:0] cst_c, npc_c;

  ifd_classify u_cls (
    .op_class (win_i[7:4]),
    .op_func  (win_i[3:0]),
    .shape    (shape)
  );

  ifd_extract #(.WORD_W(WORD_W), .WIN_BYTES(WIN_BYTES)) u_ext (
    .win   (win_i),
    .shape (shape),
    .reg_a (ra_c),
    .reg_b (rb_c),
    .cval  (cst_c)
  );

  assign npc_c = pc_i + {{(WORD_W-NIB_W){1'b0}}, shape.len};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_class_o <= '0;
      op_func_o  <= '0;
      reg_a_o    <= NO_REG;
      reg_b_o    <= NO_REG;
      const_o    <= '0;
      len_o      <= '0;
      next_pc_o  <= '0;
      bad_op_o   <= 1'b0;
    end else begin
      op_class_o <= win_i[7:4];
      op_func_o  <= win_i[3:0];
      reg_a_o    <= ra_c;
      reg_b_o    <= rb_c;
      const_o    <= cst_c;
      len_o      <= shape.len;
      next_pc_o  <= npc_c;
      bad_op_o   <= shape.bad;
    end
  end
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
  parameter int WORD_W    = 64,
  parameter int WIN_BYTES = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic [WORD_W-1:0]      pc_i,
  input logic [8*WIN_BYTES-1:0] win_i,
  input logic [3:0]             op_class_o,
  input logic [3:0]             op_func_o,
  input logic [3:0]             reg_a_o,
  input logic [3:0]             reg_b_o,
  input logic [WORD_W-1:0]      const_o,
  input logic [3:0]             len_o,
  input logic [WORD_W-1:0]      next_pc_o,
  input logic                   bad_op_o
);
  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  p_bad_len_r10: assert property (@(posedge clk) disable iff (rst)
    bad_op_o |-> (len_o == 4'd0 && reg_a_o == 4'hF && reg_b_o == 4'hF && const_o == '0));

  p_len_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (primed && !bad_op_o) |-> (len_o == 4'd1 || len_o == 4'd2 || len_o == 4'd9 || len_o == 4'd10));

  p_short_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (len_o == 4'd1) |-> (reg_a_o == 4'hF && reg_b_o == 4'hF && const_o == '0));

  p_nine_class_r5: assert property (@(posedge clk) disable iff (rst)
    (len_o == 4'd9) |-> ((op_class_o == 4'h7 || op_class_o == 4'h8) && reg_a_o == 4'hF && reg_b_o == 4'hF));

  p_ten_class_r4: assert property (@(posedge clk) disable iff (rst)
    (len_o == 4'd10) |-> (op_class_o >= 4'h3 && op_class_o <= 4'h5 && op_func_o == 4'h0));

  p_next_pc_r8: assert property (@(posedge clk) disable iff (rst)
    primed |-> (next_pc_o == $past(pc_i) + {{(WORD_W-4){1'b0}}, len_o}));

  p_class_follow_r11: assert property (@(posedge clk) disable iff (rst)
    primed |-> ({op_class_o, op_func_o} == $past(win_i[7:0])));
endmodule

bind insn_fetch_decoder ifd_checker #(.WORD_W(WORD_W), .WIN_BYTES(WIN_BYTES)) u_chk (.*);

// File: tb/insn_fetch_decoder_tb.sv
`timescale 1ns/1ps
module insn_fetch_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pc_i = '0;
  logic [79:0] win_i = '0;
  logic [3:0]  op_class_o, op_func_o, reg_a_o, reg_b_o, len_o;
  logic [63:0] const_o, next_pc_o;
  logic        bad_op_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  insn_fetch_decoder u_dut (.*);

  // Behavioural reference encoder knowledge, written from the requirements.
  task automatic model(input logic [63:0] pc, input logic [79:0] w,
                       output logic [3:0] ra, output logic [3:0] rb,
                       output logic [63:0] c, output int len,
                       output logic [63:0] npc, output logic bad);
    int cls, fn, cst_ofs;
    cls = int'(w[7:4]); fn = int'(w[3:0]);
    bad = 1'b0; len = 0; cst_ofs = 0;
    ra = 4'hF; rb = 4'hF; c = '0;
    case (cls)
      0, 1, 9:   begin len = 1;  bad = (fn != 0); end
      2:         begin len = 2;  bad = (fn > 6); end
      6:         begin len = 2;  bad = (fn > 3); end
      10, 11:    begin len = 2;  bad = (fn != 0); end
      3, 4, 5:   begin len = 10; bad = (fn != 0); cst_ofs = 2; end
      7:         begin len = 9;  bad = (fn > 6); cst_ofs = 1; end
      8:         begin len = 9;  bad = (fn != 0); cst_ofs = 1; end
      default:   bad = 1'b1;
    endcase
    if (bad) begin len = 0; cst_ofs = 0; end
    if (!bad && (len == 2 || len == 10)) begin
      ra = w[15:12]; rb = w[11:8];
    end
    if (cst_ofs != 0)
      for (int i = 7; i >= 0; i--) c = {c[55:0], w[8*(cst_ofs+i) +: 8]};
    npc = pc + 64'(len);
  endtask

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (byte0=%h)", tag, act, exp, win_i[7:0]);
    end
  endtask

  // Drive on the falling edge, compare one cycle later on the falling edge.
  task automatic apply(input logic [63:0] pc, input logic [79:0] w, input string tag);
    logic [3:0] ra, rb; logic [63:0] c, npc; int len; logic bad;
    @(negedge clk);
    pc_i = pc; win_i = w;
    model(pc, w, ra, rb, c, len, npc, bad);
    @(negedge clk);
    check64({tag, " R1 class"}, 64'(op_class_o), 64'(w[7:4]));
    check64({tag, " R1 func"},  64'(op_func_o),  64'(w[3:0]));
    check64({tag, " R7 regA"},  64'(reg_a_o),    64'(ra));
    check64({tag, " R7 regB"},  64'(reg_b_o),    64'(rb));
    check64({tag, " R6 const"}, const_o,         c);
    check64({tag, " R3 len"},   64'(len_o),      64'(len));
    check64({tag, " R8 nextpc"},next_pc_o,       npc);
    check64({tag, " R9 bad"},   64'(bad_op_o),   64'(bad));
  endtask

  function automatic logic [79:0] rnd_win(input logic [7:0] b0);
    logic [79:0] w;
    for (int i = 0; i < 10; i++) w[8*i +: 8] = 8'($urandom);
    w[7:0] = b0;
    return w;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [79:0] w;
    repeat (3) @(negedge clk);
    // R11 reset state
    check64("R11 reset regA", 64'(reg_a_o), 64'hF);
    check64("R11 reset regB", 64'(reg_b_o), 64'hF);
    check64("R11 reset len",  64'(len_o), 64'h0);
    check64("R11 reset npc",  next_pc_o, 64'h0);
    check64("R11 reset bad",  64'(bad_op_o), 64'h0);
    rst = 1'b0;

    // R6 worked example: load with displacement 0x100
    apply(64'h30, {64'h0000_0000_0000_0100, 8'h03, 8'h50}, "R6 example");
    check64("R6 example value", const_o, 64'h100);
    check64("R4 example len", 64'(len_o), 64'd10);

    // R2 single-byte forms
    apply(64'h5a, rnd_win(8'h00), "R2 halt");
    apply(64'h5b, rnd_win(8'h10), "R2 nop");
    apply(64'h5c, rnd_win(8'h90), "R2 ret");
    // R5 jump with register-looking byte 1
    apply(64'h1000, {8'h99, 64'h1122_3344_5566_7788, 8'h73}, "R5 jump");
    check64("R5 jump dest", const_o, 64'h1122_3344_5566_7788);
    // R7 no-register markers
    apply(64'h40, {64'h0, 8'hF3, 8'h30}, "R7 ldimm");
    check64("R7 ldimm regA F", 64'(reg_a_o), 64'hF);
    apply(64'h42, {64'h0, 8'h4F, 8'hA0}, "R7 push");
    check64("R7 push regB F", 64'(reg_b_o), 64'hF);
    // R8 wraparound
    apply(64'hFFFF_FFFF_FFFF_FFFA, rnd_win(8'h40), "R8 wrap");
    check64("R8 wrap value", next_pc_o, 64'h4);
    // R9/R10 boundary function codes
    apply(64'h77, rnd_win(8'h27), "R9 cmov fn7");
    apply(64'h77, rnd_win(8'h64), "R9 alu fn4");
    apply(64'h77, rnd_win(8'hC0), "R9 class C");
    check64("R10 bad npc", next_pc_o, 64'h77);
    // R1 full sweep of the leading byte, two trailing patterns each
    for (int b = 0; b < 256; b++) begin
      apply(64'($urandom) << 8, rnd_win(8'(b)), "sweep");
      apply(64'hFFFF_FFFF_FFFF_FFF8 + 64'(b % 8), rnd_win(8'(b)), "sweep hi");
    end
    // R11 reset again clears the outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check64("R11 rerst len", 64'(len_o), 64'h0);
    check64("R11 rerst const", const_o, 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule